// File: doc/BRIEF.md
# Receive FIFO with Fill-Level Interrupt

This block buffers data words coming from a serial receiver's shift logic until the CPU reads them. It holds up to 16 words in arrival order. It keeps a fill count that runs from 0 to 16 and compares that count with a threshold that software programs. When the count is at or above the threshold, a sticky interrupt flag is set. The flag drives the interrupt line only while the enable bit is set.

The receiver side has a push strobe with a data word. The CPU side has a pop strobe and a registered data output. A small register interface has two write addresses. Address 0 holds the configuration: the threshold and the interrupt enable. Address 1 takes command strobes: clear the interrupt flag, clear the overflow flag, and flush the buffer. A single status word can be read at any time.

After reset the threshold is 31. That is above the buffer depth, so the interrupt stays quiet until software lowers the threshold. A push into a full buffer loses the word and sets a sticky overflow flag.

Top module: `rx_level_fifo`

## Requirements
- R1: After synchronous reset the outputs are as follows. `fill_count` is 0. `irq_flag`, `ovf_flag` and `irq_out` are 0. `pop_data` is 0. `cfg_rdata` reads 16'h001F, which means threshold 31 and enable 0.
- R2: Words leave in the order they arrived. The buffer holds 16 words. `fill_count` and `cfg_rdata[12:8]` show the count, from 0 up to 16 (5'b10000). The count updates on the clock edge that takes a push or a pop. `pop_data` takes the head word on the edge that takes a pop.
- R3: A pop while the buffer is empty is ignored. The count stays 0 and `pop_data` keeps its last value.
- R4: A push and a pop on the same edge, with the buffer not empty, leave the count unchanged and return the head word. A push with a pop on an empty buffer stores the word and leaves `pop_data` unchanged.
- R5: A push into a full buffer with no pop loses the word and sets `ovf_flag`. `ovf_flag` stays set until a command write with bit 1 = 1 clears it. A new loss on the same edge as a clear takes priority.
- R6: `irq_flag` is set on the clock edge after the edge where `fill_count` >= threshold holds, so it is due one cycle after the count reaches the threshold. Once set, the flag stays set.
- R7: A command write (address 1) with bit 0 = 1 clears `irq_flag`. Bit 0 = 0 has no effect. If the threshold condition still holds, the set wins and the flag stays 1. Bit 6 of `cfg_rdata` always reads 0. `cfg_rdata[7]` shows the flag.
- R8: `irq_out` is 1 exactly while both `irq_flag` and the enable are set. The enable is bit 5 of a configuration write (address 0) and reads back in `cfg_rdata[5]`.
- R9: The threshold is bits 4:0 of a configuration write and reads back in `cfg_rdata[4:0]`. With the reset threshold of 31, even a full buffer never sets `irq_flag`.
- R10: A command write with bit 2 = 1 flushes the buffer, and the count is 0 on the next cycle. The threshold, the enable and both flags keep their values. A push on the same edge as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_vld | input | 1 | Receiver delivers a word |
| push_data | input | 8 | Word from the receiver |
| pop | input | 1 | CPU reads the head word |
| pop_data | output | 8 | Last word read out |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = configuration, 1 = command |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Status: [4:0] threshold, [5] enable, [7] irq flag, [12:8] count, [13] overflow |
| fill_count | output | 5 | Words held |
| irq_flag | output | 1 | Sticky threshold flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_out | output | 1 | Flag gated by the enable |

## Verification
These are the timing rules the bench relies on:
- The count and `pop_data` are due one clock after the strobe that moves them.
- Configuration values, flag clears and a flush take effect one clock after their write.
- `irq_flag` is due one clock after the count reaches the threshold, which is two clocks after the push that fills the buffer to that level.

The bench drives every input on a falling edge and samples on the next falling edge. For the flag it waits one extra falling edge, and it checks first that the flag is still low one cycle early. To show that a write which should have no effect really has none, it reads the status word back before the next stimulus.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int RXQ_DEPTH  = 16;
    localparam int RXQ_DATA_W = 8;
    localparam int RXQ_CNT_W  = $clog2(RXQ_DEPTH) + 1;
    localparam int RXQ_REG_W  = 16;

    typedef logic [RXQ_CNT_W-1:0] fill_t;

    localparam fill_t LEVEL_RST = '1;

    // configuration write, address 0
    typedef struct packed {
        logic [RXQ_REG_W-RXQ_CNT_W-2:0] spare;
        logic                           irq_en;
        fill_t                          level;
    } cfg_word_t;

    // command write, address 1
    typedef struct packed {
        logic [RXQ_REG_W-4:0] spare;
        logic                 flush;
        logic                 ovf_clr;
        logic                 irq_clr;
    } cmd_word_t;

    // status read
    typedef struct packed {
        logic [RXQ_REG_W-2*RXQ_CNT_W-5:0] spare;
        logic                             ovf;
        fill_t                            count;
        logic                             irq_flag;
        logic                             zero_b6;
        logic                             irq_en;
        fill_t                            level;
    } status_word_t;

    typedef struct packed {
        fill_t level;
        logic  irq_en;
    } cfg_t;

    function automatic logic level_reached(fill_t cnt, fill_t lvl);
        return cnt >= lvl;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              drop
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              empty, full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop & ~empty & ~flush;
    assign do_push = push & ~flush & (~full | do_pop);
    assign drop    = push & ~flush & full & ~do_pop;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= step(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= step(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_data <= '0;
        end else if (do_pop) begin
            pop_data <= mem[rd_ptr];
        end
    end

endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
    import rxq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic                 addr,
    input  logic [RXQ_REG_W-1:0] wdata,
    output cfg_t                 cfg,
    output logic                 irq_clr,
    output logic                 ovf_clr,
    output logic                 flush
);

    cfg_word_t cw;
    cmd_word_t cmd;

    assign cw  = cfg_word_t'(wdata);
    assign cmd = cmd_word_t'(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.level  <= LEVEL_RST;
            cfg.irq_en <= 1'b0;
        end else if (wr && !addr) begin
            cfg.level  <= cw.level;
            cfg.irq_en <= cw.irq_en;
        end
    end

    assign irq_clr = wr & addr & cmd.irq_clr;
    assign ovf_clr = wr & addr & cmd.ovf_clr;
    assign flush   = wr & addr & cmd.flush;

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import rxq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fill_t count,
    input  fill_t level,
    input  logic  irq_clr,
    input  logic  drop,
    input  logic  ovf_clr,
    output logic  irq_flag,
    output logic  ovf_flag
);

    logic hit;

    assign hit = level_reached(count, level);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_flag <= 1'b0;
            ovf_flag <= 1'b0;
        end else begin
            irq_flag <= hit  | (irq_flag & ~irq_clr);
            ovf_flag <= drop | (ovf_flag & ~ovf_clr);
        end
    end

endmodule

// File: rtl/rx_level_fifo.sv
module rx_level_fifo
    import rxq_pkg::*;
#(
    parameter int DATA_W = RXQ_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push_vld,
    input  logic [DATA_W-1:0]    push_data,
    input  logic                 pop,
    output logic [DATA_W-1:0]    pop_data,
    input  logic                 cfg_wr,
    input  logic                 cfg_addr,
    input  logic [RXQ_REG_W-1:0] cfg_wdata,
    output logic [RXQ_REG_W-1:0] cfg_rdata,
    output logic [RXQ_CNT_W-1:0] fill_count,
    output logic                 irq_flag,
    output logic                 ovf_flag,
    output logic                 irq_out
);

    cfg_t         cfg;
    logic         irq_clr, ovf_clr, flush, drop;
    fill_t        count;
    status_word_t st;

    rxq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (cfg_wr),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .cfg     (cfg),
        .irq_clr (irq_clr),
        .ovf_clr (ovf_clr),
        .flush   (flush)
    );

    rxq_store #(.DATA_W(DATA_W), .DEPTH(RXQ_DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (push_vld),
        .push_data (push_data),
        .pop       (pop),
        .pop_data  (pop_data),
        .count     (count),
        .drop      (drop)
    );

    rxq_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .count    (count),
        .level    (cfg.level),
        .irq_clr  (irq_clr),
        .drop     (drop),
        .ovf_clr  (ovf_clr),
        .irq_flag (irq_flag),
        .ovf_flag (ovf_flag)
    );

    always_comb begin
        st          = '0;
        st.level    = cfg.level;
        st.irq_en   = cfg.irq_en;
        st.irq_flag = irq_flag;
        st.count    = count;
        st.ovf      = ovf_flag;
    end

    assign cfg_rdata  = st;
    assign fill_count = count;
    assign irq_out    = irq_flag & cfg.irq_en;

endmodule

// File: rtl/rx_level_fifo_chk.sv
module rx_level_fifo_chk
    import rxq_pkg::*;
#(
    parameter int DATA_W = RXQ_DATA_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 push_vld,
    input logic                 pop,
    input logic [DATA_W-1:0]    pop_data,
    input logic                 cfg_wr,
    input logic                 cfg_addr,
    input logic [RXQ_REG_W-1:0] cfg_wdata,
    input logic [RXQ_REG_W-1:0] cfg_rdata,
    input logic [RXQ_CNT_W-1:0] fill_count,
    input logic                 irq_flag,
    input logic                 ovf_flag,
    input logic                 irq_out
);

    logic clr_wr, flush_wr, ovf_clr_wr;
    assign clr_wr     = cfg_wr & cfg_addr & cfg_wdata[0];
    assign ovf_clr_wr = cfg_wr & cfg_addr & cfg_wdata[1];
    assign flush_wr   = cfg_wr & cfg_addr & cfg_wdata[2];

    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill_count <= RXQ_CNT_W'(RXQ_DEPTH));

    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && fill_count == '0 && !push_vld && !flush_wr) |=> (fill_count == '0 && $stable(pop_data)));

    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (push_vld && !pop && !flush_wr && fill_count == RXQ_CNT_W'(RXQ_DEPTH)) |=> ovf_flag);

    // R5
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr_wr) |=> ovf_flag);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_count >= cfg_rdata[RXQ_CNT_W-1:0]) |=> irq_flag);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !clr_wr) |=> irq_flag);

    // R7
    clr_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[6] == 1'b0);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (irq_flag && cfg_rdata[5]));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush_wr |=> (fill_count == '0 && $stable(cfg_rdata[5:0])));

endmodule

bind rx_level_fifo rx_level_fifo_chk #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .push_vld   (push_vld),
    .pop        (pop),
    .pop_data   (pop_data),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .fill_count (fill_count),
    .irq_flag   (irq_flag),
    .ovf_flag   (ovf_flag),
    .irq_out    (irq_out)
);

// File: tb/test_rx_level_fifo.sv
module test_rx_level_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_vld = 1'b0;
    logic [7:0]  push_data = '0;
    logic        pop = 1'b0;
    logic [7:0]  pop_data;
    logic        cfg_wr = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [4:0]  fill_count;
    logic        irq_flag, ovf_flag, irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rx_level_fifo i_rx_level_fifo (
        .clk(clk), .rst(rst), .push_vld(push_vld), .push_data(push_data),
        .pop(pop), .pop_data(pop_data), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fill_count(fill_count),
        .irq_flag(irq_flag), .ovf_flag(ovf_flag), .irq_out(irq_out)
    );

    task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    task automatic push1(logic [7:0] d);
        push_vld = 1'b1; push_data = d;
        @(negedge clk);
        push_vld = 1'b0;
    endtask

    task automatic pop1();
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
    endtask

    task automatic wreg(logic a, logic [15:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic t_reset();
        chk("R1 count", fill_count, 0);
        chk("R1 irq_flag", irq_flag, 0);
        chk("R1 ovf_flag", ovf_flag, 0);
        chk("R1 irq_out", irq_out, 0);
        chk("R1 rdata", cfg_rdata, 16'h001F);
        chk("R1 pop_data", pop_data, 0);
    endtask

    task automatic t_fill_order();
        for (int i = 0; i < 16; i++) begin
            push1(8'hA0 + 8'(i));
            chk("R2 count up", fill_count, i + 1);
        end
        chk("R2 rdata count", cfg_rdata[12:8], 16);
        @(negedge clk);
        chk("R9 no flag at reset level", irq_flag, 0);
        for (int i = 0; i < 16; i++) begin
            pop1();
            chk("R2 order", pop_data, 8'hA0 + 8'(i));
            chk("R2 count down", fill_count, 15 - i);
        end
    endtask

    task automatic t_pop_empty();
        pop1();
        chk("R3 count", fill_count, 0);
        chk("R3 data held", pop_data, 8'hAF);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 16; i++) push1(8'(i));
        chk("R5 no ovf yet", ovf_flag, 0);
        push1(8'h55);
        chk("R5 count", fill_count, 16);
        chk("R5 ovf set", ovf_flag, 1);
        for (int i = 0; i < 16; i++) begin
            pop1();
            chk("R5 stored", pop_data, 8'(i));
        end
        chk("R5 ovf sticky", ovf_flag, 1);
        wreg(1'b1, 16'h0002);
        chk("R5 ovf clear", ovf_flag, 0);
    endtask

    task automatic t_push_pop();
        push1(8'h11);
        push1(8'h22);
        push_vld = 1'b1; push_data = 8'h33; pop = 1'b1;
        @(negedge clk);
        push_vld = 1'b0; pop = 1'b0;
        chk("R4 count same", fill_count, 2);
        chk("R4 head", pop_data, 8'h11);
        pop1(); chk("R4 data", pop_data, 8'h22);
        pop1(); chk("R4 data", pop_data, 8'h33);
        push_vld = 1'b1; push_data = 8'h44; pop = 1'b1;
        @(negedge clk);
        push_vld = 1'b0; pop = 1'b0;
        chk("R4 empty push+pop count", fill_count, 1);
        chk("R4 empty push+pop data", pop_data, 8'h33);
        pop1(); chk("R4 stored", pop_data, 8'h44);
    endtask

    task automatic t_level();
        wreg(1'b0, 16'h0024);
        chk("R9 level readback", cfg_rdata[5:0], 6'h24);
        for (int i = 0; i < 3; i++) push1(8'(i));
        @(negedge clk);
        chk("R6 below level", irq_flag, 0);
        push1(8'h03);
        chk("R6 not one cycle early", irq_flag, 0);
        @(negedge clk);
        chk("R6 flag set", irq_flag, 1);
        chk("R8 irq_out on", irq_out, 1);
        chk("R7 flag in rdata", cfg_rdata[7], 1);
        wreg(1'b1, 16'h0000);
        chk("R7 write zero no effect", irq_flag, 1);
        wreg(1'b1, 16'h0001);
        chk("R7 set wins over clear", irq_flag, 1);
        pop1();
        wreg(1'b1, 16'h0001);
        chk("R7 cleared", irq_flag, 0);
        chk("R7 bit6 zero", cfg_rdata[6], 0);
        chk("R6 stays clear below", irq_flag, 0);
    endtask

    task automatic t_gate();
        wreg(1'b0, 16'h0004);
        push1(8'h09);
        @(negedge clk);
        chk("R8 flag set", irq_flag, 1);
        chk("R8 gated off", irq_out, 0);
        wreg(1'b0, 16'h0024);
        chk("R8 enabled", irq_out, 1);
    endtask

    task automatic t_flush();
        wreg(1'b1, 16'h0004);
        chk("R10 count zero", fill_count, 0);
        chk("R10 cfg kept", cfg_rdata[5:0], 6'h24);
        chk("R10 flag kept", irq_flag, 1);
        push1(8'h77);
        pop1();
        chk("R10 clean after flush", pop_data, 8'h77);
        push_vld = 1'b1; push_data = 8'h88;
        cfg_wr = 1'b1; cfg_addr = 1'b1; cfg_wdata = 16'h0004;
        @(negedge clk);
        push_vld = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0;
        chk("R10 push dropped on flush", fill_count, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill_order();
        t_pop_empty();
        t_overflow();
        t_push_pop();
        t_level();
        t_gate();
        t_flush();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule